// File: doc/BRIEF.md
# DDR Byte Lane Data Path

This block moves data between a 16-bit word on the system side and an 8-bit double-data-rate bus on the memory side. It also derives the differential memory clock, which toggles once per system clock, so the memory runs at half the system rate. A write sends one word as a burst of two beats. The lower byte goes out while the memory clock is high and the upper byte while it is low. The block drives the data strobe so that each strobe edge falls in the middle of a beat, and frames the burst with one low preamble half-cycle before it and one low postamble half-cycle after it.

A read works the other way. The byte present at the rising strobe edge returned by the memory is taken as the lower byte, and the byte at the falling edge as the upper byte. The two bytes are joined into a word and handed to the system clock domain with a single-cycle valid pulse. The pads stay outside the block. Every bidirectional line appears as an output value, an output enable and an input value. When an enable is low, the pad outside the block must put that line into high impedance. The strobe must reach the read inputs already shifted into the data eye by an external delay element.

Top module: `ddr_byte_lane`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `dq_oe`, `dqs_oe` and `rd_valid` are 0, `mem_ck` is 0 and `mem_ck_n` is 1.
- R2: Out of reset, `mem_ck` inverts on every rising `clk` edge and `mem_ck_n` is always its complement.
- R3: In a write burst, `dq_oe` is high for exactly two system cycles. In the first cycle `mem_ck` is 1 and `dq_o` carries `wr_data[7:0]`. In the second cycle `mem_ck` is 0 and `dq_o` carries `wr_data[15:8]`. `dq_oe` is 0 in every other cycle.
- R4: The strobe outputs change on the falling `clk` edge, which is the middle of each half memory period. During the preamble half-cycle `dqs_oe` is 1 and `dqs_o` is 0. `dqs_o` is 1 in the middle of the lower beat and 0 in the middle of the upper beat and the postamble. After the postamble `dqs_oe` returns to 0.
- R5: A `wr_go` pulse seen while idle with `mem_ck` at 1 starts the preamble in the next cycle. With `mem_ck` at 0, it starts the preamble one cycle later. Either way the lower beat starts on a rising memory clock.
- R6: A `wr_go` pulse during a burst, from acceptance until the postamble ends, is ignored. The burst in flight and the data it sends are not changed, and no second burst follows.
- R7: While `rd_en` is 1, the `dq_i` byte present at a rising `dqs_i` edge becomes `rd_data[7:0]` and the byte present at the following falling edge becomes `rd_data[15:8]`.
- R8: `rd_valid` is high for exactly one cycle, after the third rising `clk` edge that follows the falling `dqs_i` edge. `rd_data` changes only together with that pulse and holds its value until the next pulse.
- R9: `dqs_i` edges that arrive while `rd_en` is 0 produce no `rd_valid` pulse and leave `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_go | input | 1 | One-cycle write request |
| wr_data | input | 16 | Word to write, lower byte first |
| rd_en | input | 1 | Read capture enable from the controller |
| rd_data | output | 16 | Reassembled read word |
| rd_valid | output | 1 | One-cycle pulse, new `rd_data` |
| mem_ck | output | 1 | Memory clock, half the system rate |
| mem_ck_n | output | 1 | Complement of `mem_ck` |
| dq_o | output | 8 | Data byte to the pad |
| dq_oe | output | 1 | Data pad output enable |
| dq_i | input | 8 | Data byte from the pad |
| dqs_o | output | 1 | Strobe value to the pad |
| dqs_oe | output | 1 | Strobe pad output enable |
| dqs_i | input | 1 | Strobe from the pad, already delayed into the eye |

## Verification
On a write, the bench notes the phase of `mem_ck` before the request. It then predicts the cycle that holds the preamble: the first cycle after the request if `mem_ck` was 1, the second if it was 0. Each beat follows in the next cycle. The data outputs are sampled 2 ns after each rising edge, and the strobe outputs 2 ns after each falling edge, which is when the falling-edge register has settled. On a read, the bench drives the falling strobe edge just after a rising clock edge, waits three rising edges before it expects `rd_valid`, and checks one edge later that the pulse has ended.

// File: rtl/ddr_lane_pkg.sv
package ddr_lane_pkg;
  typedef enum logic [2:0] {
    WS_IDLE,
    WS_ARM,
    WS_PRE,
    WS_BEAT0,
    WS_BEAT1,
    WS_POST
  } wr_state_t;
endpackage

// File: rtl/ddr_ck_gen.sv
module ddr_ck_gen (
  input  logic clk,
  input  logic rst,
  output logic ck,
  output logic ck_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ck   <= 1'b0;
      ck_n <= 1'b1;
    end else begin
      ck   <= ~ck;
      ck_n <= ck;
    end
  end

  // R2: the two registers stay complementary
  a_r2_ck_pair: assert property (@(posedge clk) disable iff (rst) ck_n == ~ck);
endmodule

// File: rtl/ddr_wr_path.sv
module ddr_wr_path
  import ddr_lane_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ck,
  input  logic              wr_go,
  input  logic [WORD_W-1:0] wr_data,
  output logic [BYTE_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              dqs_o,
  output logic              dqs_oe
);
  wr_state_t         state, nxt;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    nxt = state;
    unique case (state)
      WS_IDLE:  if (wr_go) nxt = ck ? WS_PRE : WS_ARM;
      WS_ARM:   nxt = WS_PRE;
      WS_PRE:   nxt = WS_BEAT0;
      WS_BEAT0: nxt = WS_BEAT1;
      WS_BEAT1: nxt = WS_POST;
      WS_POST:  nxt = WS_IDLE;
      default:  nxt = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= WS_IDLE;
      word_q <= '0;
      dq_o   <= '0;
      dq_oe  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == WS_IDLE && wr_go) word_q <= wr_data;
      dq_oe <= (nxt == WS_BEAT0) || (nxt == WS_BEAT1);
      if (nxt == WS_BEAT0)      dq_o <= word_q[BYTE_W-1:0];
      else if (nxt == WS_BEAT1) dq_o <= word_q[WORD_W-1:BYTE_W];
      else                      dq_o <= '0;
    end
  end

  // Strobe register on the falling edge: its edges land mid-beat
  always_ff @(negedge clk) begin
    if (rst) begin
      dqs_o  <= 1'b0;
      dqs_oe <= 1'b0;
    end else begin
      dqs_o  <= (state == WS_BEAT0);
      dqs_oe <= (state == WS_PRE) || (state == WS_BEAT0) ||
                (state == WS_BEAT1) || (state == WS_POST);
    end
  end

  // R6: a request during a burst leaves the held word alone
  a_r6_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (state != WS_IDLE) && wr_go |=> $stable(word_q));
  // R3: the lower beat starts only with the memory clock high
  a_r3_beat0_phase: assert property (@(posedge clk) disable iff (rst)
    (state == WS_BEAT0) |-> ck);
endmodule

// File: rtl/ddr_rd_path.sv
module ddr_rd_path #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] dq_i,
  input  logic              dqs_i,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [BYTE_W-1:0]      lo_q, hi_q;
  logic                   tog;
  logic [SYNC_STAGES-1:0] sy;
  logic                   tog_d;
  logic                   pulse;

  always_ff @(posedge dqs_i or posedge rst) begin
    if (rst)        lo_q <= '0;
    else if (rd_en) lo_q <= dq_i;
  end

  always_ff @(negedge dqs_i or posedge rst) begin
    if (rst) begin
      hi_q <= '0;
      tog  <= 1'b0;
    end else if (rd_en) begin
      hi_q <= dq_i;
      tog  <= ~tog;
    end
  end

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sy <= '0;
        else     sy <= {sy[SYNC_STAGES-2:0], tog};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sy <= '0;
        else     sy <= tog;
      end
    end
  endgenerate

  assign pulse = sy[SYNC_STAGES-1] ^ tog_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_d    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      tog_d    <= sy[SYNC_STAGES-1];
      rd_valid <= pulse;
      if (pulse) rd_data <= {hi_q, lo_q};
    end
  end

  // R8: single-cycle valid, data moves only with it
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> rd_valid);
endmodule

// File: rtl/ddr_byte_lane.sv
module ddr_byte_lane #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              mem_ck,
  output logic              mem_ck_n,
  output logic [BYTE_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [BYTE_W-1:0] dq_i,
  output logic              dqs_o,
  output logic              dqs_oe,
  input  logic              dqs_i
);
  ddr_ck_gen u_ck (
    .clk  (clk),
    .rst  (rst),
    .ck   (mem_ck),
    .ck_n (mem_ck_n)
  );

  ddr_wr_path #(.BYTE_W(BYTE_W)) u_wr (
    .clk     (clk),
    .rst     (rst),
    .ck      (mem_ck),
    .wr_go   (wr_go),
    .wr_data (wr_data),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe),
    .dqs_o   (dqs_o),
    .dqs_oe  (dqs_oe)
  );

  ddr_rd_path #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .dq_i     (dq_i),
    .dqs_i    (dqs_i),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // R1: reset state of the outputs
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> !dq_oe && !dqs_oe && !rd_valid && !mem_ck && mem_ck_n);
  // R3: data drive begins on a high memory clock and lasts two beats
  a_r3_first_beat: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> mem_ck);
  a_r3_two_beats: assert property (@(posedge clk) disable iff (rst)
    dq_oe && $past(dq_oe) |=> !dq_oe);
  // R4: strobe is driven whenever data is driven
  a_r4_strobe_covers: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> dqs_oe);
endmodule

// File: tb/tb_ddr_byte_lane.sv
module tb_ddr_byte_lane;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_go = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        mem_ck, mem_ck_n;
  logic [7:0]  dq_o;
  logic        dq_oe;
  logic [7:0]  dq_i = '0;
  logic        dqs_o, dqs_oe;
  logic        dqs_i = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [15:0] last_rd = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ddr_byte_lane dut (
    .clk(clk), .rst(rst), .wr_go(wr_go), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_ck(mem_ck), .mem_ck_n(mem_ck_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .dqs_o(dqs_o), .dqs_oe(dqs_oe),
    .dqs_i(dqs_i)
  );

  localparam logic [15:0] VEC [6] = '{16'hA55A, 16'h0001, 16'h8000,
                                      16'hFFFF, 16'h1234, 16'hC3E7};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Write one word; waits until mem_ck==ph; optional intruding request
  task automatic wr_burst(input logic [15:0] w, input bit ph, input bit poke);
    int d;
    int j;
    @(negedge clk);
    while (mem_ck != ph) @(negedge clk);
    d = ph ? 0 : 1;
    wr_go = 1'b1;
    wr_data = w;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      #2;
      if (k == 0) wr_go = 1'b0;
      if (k == 1 && poke) begin
        wr_go = 1'b1;
        wr_data = ~w;
      end
      if (k == 2) wr_go = 1'b0;
      j = k - d;
      chk(dq_oe == (j == 1 || j == 2), "R3 dq_oe", dq_oe, (j == 1 || j == 2));
      if (j == 1) begin
        chk(dq_o == w[7:0], "R3 lower beat", dq_o, w[7:0]);
        chk(mem_ck == 1'b1, "R5 beat on rising mem_ck", mem_ck, 1);
      end
      if (j == 2) chk(dq_o == w[15:8], "R3 upper beat", dq_o, w[15:8]);
      if (poke && k > 4) chk(dq_oe == 1'b0, "R6 no second burst", dq_oe, 0);
      #4;
      chk(dqs_oe == (j >= 0 && j <= 3), "R4 dqs_oe", dqs_oe, (j >= 0 && j <= 3));
      if (j >= 0 && j <= 3) chk(dqs_o == (j == 1), "R4 dqs level", dqs_o, (j == 1));
    end
  endtask

  // Read burst: edge-aligned data with the strobe shifted 1 ns into the eye
  task automatic rd_burst(input logic [15:0] w, input bit en);
    @(negedge clk);
    rd_en = en;
    dq_i = w[7:0];
    #1 dqs_i = 1'b1;
    #2 dq_i = w[15:8];
    #2 dqs_i = 1'b0;
    if (en) begin
      repeat (3) @(posedge clk);
      #2;
      chk(rd_valid == 1'b1, "R8 valid on third edge", rd_valid, 1);
      chk(rd_data == w, "R7 byte order", rd_data, w);
      last_rd = w;
      @(posedge clk);
      #2;
      chk(rd_valid == 1'b0, "R8 one-cycle pulse", rd_valid, 0);
      chk(rd_data == w, "R8 data held", rd_data, w);
    end else begin
      for (int k = 0; k < 5; k++) begin
        @(posedge clk);
        #2;
        chk(rd_valid == 1'b0, "R9 no pulse when disabled", rd_valid, 0);
      end
      chk(rd_data == last_rd, "R9 data unchanged", rd_data, last_rd);
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state, sampled after the last reset edge
    chk(dq_oe == 0, "R1 dq_oe", dq_oe, 0);
    chk(dqs_oe == 0, "R1 dqs_oe", dqs_oe, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(mem_ck == 0 && mem_ck_n == 1, "R1 mem clock", {mem_ck, mem_ck_n}, 2'b01);
    rst = 1'b0;

    // R2 clock toggling
    for (int k = 0; k < 6; k++) begin
      @(posedge clk);
      #2;
      chk(mem_ck == ((k % 2) == 0), "R2 mem_ck toggles", mem_ck, ((k % 2) == 0));
      chk(mem_ck_n == ~mem_ck, "R2 complement", mem_ck_n, ~mem_ck);
    end

    // Vector table: write then read each word, alternating start phase
    for (int i = 0; i < 6; i++) begin
      wr_burst(VEC[i], (i % 2) == 0, 1'b0);
      rd_burst(VEC[i], 1'b1);
    end

    // R5 both phases explicitly, R6 intruding request
    wr_burst(16'h5AA5, 1'b0, 1'b0);
    wr_burst(16'h3C96, 1'b1, 1'b0);
    wr_burst(16'h0FF0, 1'b1, 1'b1);
    wr_burst(16'hBEEF, 1'b0, 1'b1);

    // R9 disabled capture, then R7 capture again
    rd_burst(16'hDEAD, 1'b0);
    rd_burst(16'h7E81, 1'b1);
    rd_burst(16'h0000, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule